// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces the horizontal and vertical timing of a raster display from six programmable timing words. A small register file sits on a single-cycle write/read bus. Software opens it with a key, writes the timing words and a run bit, and the block then scans a pixel counter and a line counter. From those counts it decodes active video, blanking, horizontal sync and vertical sync, all active-high. Each timing word packs two boundaries, each stored as the boundary minus one. The start-type boundary sits in bits 15:0 and the end-type boundary in bits 31:16. The intended order along a line or frame is: active region, blank start (equal to the active width), front porch, sync, back porch, and blank end (equal to the total).

Two small state machines control the block. The lock machine has the states SHUT (the reset state) and OPEN. A bus write of the key to the key register moves SHUT to OPEN. A bus write of any other value to the key register moves OPEN to SHUT. The scan machine has the states IDLE (the reset state) and SCAN. When the run bit is set, it moves from IDLE to SCAN. When the run bit is cleared, it moves from SCAN back to IDLE. In IDLE both counters are zero and every timing output is low. Reprogramming therefore goes: open, clear run, write the timing words, set run, shut.

Top module: `raster_tgen_top`

## Requirements
- R1: After reset the register file is shut and every register reads 0. Both counters are 0 and vid_active, vid_blank, hsync and vsync are low.
- R2: A write of 0x00004758 to address 0 opens the register file. A write of any other value to address 0 shuts it. Address 0 accepts writes in both states and reads back the last value written.
- R3: While the register file is shut, a write to addresses 1 to 7 is dropped and the register keeps its value. Reads return the stored value whether the file is shut or open.
- R4: The register map is as follows. Address 1 holds the run bit in bit 0. Addresses 2, 3 and 4 hold the horizontal words: active/total, blank start/end and sync start/end. Addresses 5, 6 and 7 hold the same three words for the vertical direction. In each timing word, bits 15:0 hold the start-type field (boundary minus one) and bits 31:16 hold the end-type field.
- R5: Suppose the write that sets the run bit is sampled at clock edge k. From edge k+1 the block is scanning with both counts at 0. The pixel count then rises by one on every edge.
- R6: After the pixel count reaches the horizontal total field, it returns to 0 on the next edge and the line count rises by one. After the line count reaches the vertical total field, it returns to 0 at that line wrap.
- R7: hsync is high when the pixel count is greater than the horizontal sync start field and at or below the horizontal sync end field. vsync follows the same rule on the line count, using the vertical sync word.
- R8: vid_blank is high when the pixel count lies in the range (horizontal blank start field, horizontal blank end field]. It is also high when the line count lies in the same kind of range of the vertical blank word.
- R9: vid_active is high when the pixel count is at or below the horizontal active field and the line count is at or below the vertical active field.
- R10: Suppose the write that clears the run bit is sampled at edge k. From edge k+1 both counts are 0 and all four timing outputs are low, and they stay that way until the run bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; also clocks the register bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at bus_addr (combinational) |
| h_count | output | 16 | Pixel counter |
| v_count | output | 16 | Line counter |
| vid_active | output | 1 | Active video region |
| vid_blank | output | 1 | Horizontal or vertical blanking |
| hsync | output | 1 | Horizontal sync, active-high |
| vsync | output | 1 | Vertical sync, active-high |

## Verification
The bench derives when each result is due from the number of registers on its path. A register write takes effect at the edge that samples it, so a readback in the following low clock phase already shows the new value, and bus_rdata is combinational on bus_addr. A change to the run bit passes through the stored run bit and then the scan state, so the counters and outputs respond one edge later. The bench therefore first checks the half-cycle in which the block must still be idle, and then checks the half-cycle in which scanning has begun. The four timing outputs decode the counters without a register, so every sample compares them with the expected counts of that same low phase.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = WORD_W / 2;
    localparam int ADDR_W  = 3;

    localparam logic [WORD_W-1:0] OPEN_KEY = 32'h0000_4758;

    typedef enum logic [ADDR_W-1:0] {
        A_KEY  = 3'd0,
        A_CFG  = 3'd1,
        A_HACT = 3'd2,
        A_HBLK = 3'd3,
        A_HSYN = 3'd4,
        A_VACT = 3'd5,
        A_VBLK = 3'd6,
        A_VSYN = 3'd7
    } reg_addr_e;

    typedef enum logic {
        LK_SHUT = 1'b0,
        LK_OPEN = 1'b1
    } lock_e;

    typedef enum logic {
        TG_IDLE = 1'b0,
        TG_SCAN = 1'b1
    } scan_e;

endpackage

// File: rtl/tgen_regs.sv
module tgen_regs
    import tgen_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              run_bit,
    output logic [DATA_W-1:0] hact_w,
    output logic [DATA_W-1:0] hblk_w,
    output logic [DATA_W-1:0] hsyn_w,
    output logic [DATA_W-1:0] vact_w,
    output logic [DATA_W-1:0] vblk_w,
    output logic [DATA_W-1:0] vsyn_w
);

    localparam int NREG = 1 << ADDR_W;

    lock_e             lk_q, lk_d;
    logic [DATA_W-1:0] regs [NREG];
    logic              key_wr;

    assign key_wr = wr_en && (addr == A_KEY);

    // lock state machine: next state
    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_SHUT: if (key_wr && (wdata == OPEN_KEY)) lk_d = LK_OPEN;
            LK_OPEN: if (key_wr && (wdata != OPEN_KEY)) lk_d = LK_SHUT;
        endcase
    end

    // lock state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_SHUT;
        else        lk_q <= lk_d;
    end

    // storage: key word always writable, the rest only while open
    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        if (gi == 0) begin : g_key
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      regs[gi] <= '0;
                else if (key_wr) regs[gi] <= wdata;
            end
        end else begin : g_gated
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[gi] <= '0;
                else if (wr_en && (addr == ADDR_W'(gi)) && (lk_q == LK_OPEN))
                    regs[gi] <= wdata;
            end
        end
    end

    assign rdata   = regs[addr];
    assign run_bit = regs[A_CFG][0];
    assign hact_w  = regs[A_HACT];
    assign hblk_w  = regs[A_HBLK];
    assign hsyn_w  = regs[A_HSYN];
    assign vact_w  = regs[A_VACT];
    assign vblk_w  = regs[A_VBLK];
    assign vsyn_w  = regs[A_VSYN];

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata == OPEN_KEY) |=> (lk_q == LK_OPEN)); // R2

    AST_BAD_KEY_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata != OPEN_KEY) |=> (lk_q == LK_SHUT)); // R2

    AST_SHUT_DROPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_SHUT && wr_en && addr == A_CFG) |=> $stable(run_bit)); // R3

    AST_SHUT_DROPS_HTOT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_SHUT && wr_en && addr == A_HACT) |=> $stable(hact_w)); // R3

endmodule

// File: rtl/tgen_scan.sv
module tgen_scan
    import tgen_pkg::*;
#(
    parameter int CNT_W = FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic [CNT_W-1:0] h_last,
    input  logic [CNT_W-1:0] v_last,
    output logic [CNT_W-1:0] h_cnt,
    output logic [CNT_W-1:0] v_cnt,
    output logic             scanning
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    scan_e state_q, state_d;

    // scan state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TG_IDLE: if (run_req)  state_d = TG_SCAN;
            TG_SCAN: if (!run_req) state_d = TG_IDLE;
        endcase
    end

    // scan state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TG_IDLE;
        else        state_q <= state_d;
    end

    // counters advance only while scanning and still requested
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (state_q == TG_SCAN && run_req) begin
            if (h_cnt >= h_last) begin
                h_cnt <= '0;
                v_cnt <= (v_cnt >= v_last) ? '0 : v_cnt + ONE;
            end else begin
                h_cnt <= h_cnt + ONE;
            end
        end else begin
            h_cnt <= '0;
            v_cnt <= '0;
        end
    end

    assign scanning = (state_q == TG_SCAN);

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TG_IDLE) |-> (h_cnt == '0 && v_cnt == '0)); // R10

    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TG_SCAN && run_req && h_cnt < h_last)
        |=> (state_q == TG_IDLE || h_cnt == $past(h_cnt) + ONE)); // R5

    AST_V_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TG_SCAN && $past(state_q) == TG_SCAN && h_cnt != '0)
        |-> $stable(v_cnt)); // R6

endmodule

// File: rtl/tgen_window.sv
module tgen_window
    import tgen_pkg::*;
#(
    parameter int CNT_W = FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scanning,
    input  logic [CNT_W-1:0] h_cnt,
    input  logic [CNT_W-1:0] v_cnt,
    input  logic [CNT_W-1:0] h_act,
    input  logic [CNT_W-1:0] v_act,
    input  logic [CNT_W-1:0] hb_lo,
    input  logic [CNT_W-1:0] hb_hi,
    input  logic [CNT_W-1:0] vb_lo,
    input  logic [CNT_W-1:0] vb_hi,
    input  logic [CNT_W-1:0] hs_lo,
    input  logic [CNT_W-1:0] hs_hi,
    input  logic [CNT_W-1:0] vs_lo,
    input  logic [CNT_W-1:0] vs_hi,
    output logic             active,
    output logic             blank,
    output logic             hs,
    output logic             vs
);

    function automatic logic past_lo_upto_hi(
        input logic [CNT_W-1:0] c,
        input logic [CNT_W-1:0] lo,
        input logic [CNT_W-1:0] hi
    );
        return (c > lo) && (c <= hi);
    endfunction

    always_comb begin
        active = 1'b0;
        blank  = 1'b0;
        hs     = 1'b0;
        vs     = 1'b0;
        if (scanning) begin
            active = (h_cnt <= h_act) && (v_cnt <= v_act);
            blank  = past_lo_upto_hi(h_cnt, hb_lo, hb_hi)
                   || past_lo_upto_hi(v_cnt, vb_lo, vb_hi);
            hs     = past_lo_upto_hi(h_cnt, hs_lo, hs_hi);
            vs     = past_lo_upto_hi(v_cnt, vs_lo, vs_hi);
        end
    end

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !scanning |-> !(active || blank || hs || vs)); // R10

endmodule

// File: rtl/raster_tgen_top.sv
module raster_tgen_top
    import tgen_pkg::*;
#(
    parameter int CNT_W  = FIELD_W,
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  h_count,
    output logic [CNT_W-1:0]  v_count,
    output logic              vid_active,
    output logic              vid_blank,
    output logic              hsync,
    output logic              vsync
);

    localparam int HI_POS = DATA_W / 2;

    logic              run_bit, scanning;
    logic [DATA_W-1:0] hact_w, hblk_w, hsyn_w, vact_w, vblk_w, vsyn_w;

    tgen_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .run_bit (run_bit),
        .hact_w  (hact_w),
        .hblk_w  (hblk_w),
        .hsyn_w  (hsyn_w),
        .vact_w  (vact_w),
        .vblk_w  (vblk_w),
        .vsyn_w  (vsyn_w)
    );

    tgen_scan #(.CNT_W(CNT_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_req  (run_bit),
        .h_last   (hact_w[HI_POS +: CNT_W]),
        .v_last   (vact_w[HI_POS +: CNT_W]),
        .h_cnt    (h_count),
        .v_cnt    (v_count),
        .scanning (scanning)
    );

    tgen_window #(.CNT_W(CNT_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .scanning (scanning),
        .h_cnt    (h_count),
        .v_cnt    (v_count),
        .h_act    (hact_w[CNT_W-1:0]),
        .v_act    (vact_w[CNT_W-1:0]),
        .hb_lo    (hblk_w[CNT_W-1:0]),
        .hb_hi    (hblk_w[HI_POS +: CNT_W]),
        .vb_lo    (vblk_w[CNT_W-1:0]),
        .vb_hi    (vblk_w[HI_POS +: CNT_W]),
        .hs_lo    (hsyn_w[CNT_W-1:0]),
        .hs_hi    (hsyn_w[HI_POS +: CNT_W]),
        .vs_lo    (vsyn_w[CNT_W-1:0]),
        .vs_hi    (vsyn_w[HI_POS +: CNT_W]),
        .active   (vid_active),
        .blank    (vid_blank),
        .hs       (hsync),
        .vs       (vsync)
    );

    AST_RUN_STARTS_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scanning) |-> (h_count == '0 && v_count == '0)); // R5

endmodule

// File: tb/raster_tgen_top_tb_top.sv
`timescale 1ns/1ps
module raster_tgen_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] h_count, v_count;
    logic        vid_active, vid_blank, hsync, vsync;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    raster_tgen_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .h_count(h_count),
        .v_count(v_count), .vid_active(vid_active), .vid_blank(vid_blank),
        .hsync(hsync), .vsync(vsync)
    );

    // {addr, write data, expected readback of addr}; starts shut (R2, R3, R4)
    localparam logic [66:0] VEC [9] = '{
        {3'd2, 32'h0005_0007, 32'h0000_0000},
        {3'd0, 32'h1234_5678, 32'h1234_5678},
        {3'd2, 32'h0009_0007, 32'h0000_0000},
        {3'd0, 32'h0000_4758, 32'h0000_4758},
        {3'd2, 32'h0009_0007, 32'h0009_0007},
        {3'd0, 32'h0000_4759, 32'h0000_4759},
        {3'd2, 32'h1111_1111, 32'h0009_0007},
        {3'd0, 32'h0000_4758, 32'h0000_4758},
        {3'd7, 32'hABCD_1234, 32'hABCD_1234}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #0.5 check(req, bus_rdata, exp);
    endtask

    task automatic check_outputs(input string tag, input int eh, input int ev);
        check({tag, " R6 h_count"}, 32'(h_count), 32'(eh));
        check({tag, " R6 v_count"}, 32'(v_count), 32'(ev));
        check({tag, " R9 vid_active"}, 32'(vid_active), 32'(eh <= 3 && ev <= 1));
        check({tag, " R8 vid_blank"}, 32'(vid_blank),
              32'((eh > 3 && eh <= 9) || (ev > 1 && ev <= 5)));
        check({tag, " R7 hsync"}, 32'(hsync), 32'(eh > 5 && eh <= 7));
        check({tag, " R7 vsync"}, 32'(vsync), 32'(ev > 2 && ev <= 3));
    endtask

    task automatic check_dark(input string req);
        check({req, " h_count"}, 32'(h_count), 0);
        check({req, " v_count"}, 32'(v_count), 0);
        check({req, " outputs"}, {28'd0, vid_active, vid_blank, hsync, vsync}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R1 run did not complete)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int eh, ev, h1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check_dark("R1");
        for (int a = 0; a < 8; a++) bus_read_check("R1 readback", 3'(a), 32'h0);

        // R2 R3 R4: table of lock/gated writes
        for (int i = 0; i < 9; i++) begin
            bus_write(VEC[i][66:64], VEC[i][63:32]);
            bus_read_check("R2 R3 R4 table", VEC[i][66:64], VEC[i][31:0]);
        end

        // open, program mode: H total 10, act 4, sync 6..7; V total 6, act 2, sync 3
        bus_write(3'd2, 32'h0009_0003);
        bus_write(3'd3, 32'h0009_0003);
        bus_write(3'd4, 32'h0007_0005);
        bus_write(3'd5, 32'h0005_0001);
        bus_write(3'd6, 32'h0005_0001);
        bus_write(3'd7, 32'h0003_0002);
        bus_read_check("R4 vsync word", 3'd7, 32'h0003_0002);

        // R5: run bit set at edge k; idle in the following low phase, scanning after k+1
        bus_write(3'd1, 32'h1);
        @(negedge clk);
        check_dark("R5 before start");
        eh = 0; ev = 0;
        for (int n = 0; n < 130; n++) begin
            @(negedge clk);
            check_outputs("R5 scan", eh, ev);
            if (eh == 9) begin
                eh = 0;
                ev = (ev == 5) ? 0 : ev + 1;
            end else begin
                eh = eh + 1;
            end
        end

        // R3: shut, then a write clearing the run bit must be dropped
        bus_write(3'd0, 32'h0);
        bus_write(3'd1, 32'h0);
        @(negedge clk);
        h1 = int'(h_count);
        @(negedge clk);
        check("R3 still counting", 32'(h_count), 32'((h1 == 9) ? 0 : h1 + 1));
        bus_read_check("R3 run bit kept", 3'd1, 32'h1);

        // R10: open, clear run bit
        bus_write(3'd0, 32'h0000_4758);
        bus_write(3'd1, 32'h0);
        @(negedge clk);
        @(negedge clk);
        check_dark("R10 stopped");
        repeat (4) @(negedge clk);
        check_dark("R10 held");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule